// File: doc/BRIEF.md
# Overcurrent Trip, Alert and Latch Protection Controller

This block guards a battery pack's discharge path. It watches a signed current sample on every clock. When the current stays strictly above a programmed level for a programmed number of timebase ticks, it trips. A trip opens the discharge switch, and also the charge switch when the configuration asks for both. Each trip adds one to a fault counter. While the counter is nonzero and no latch is set, an alert flag is raised. The counter drains by one at a fixed tick interval, so an isolated current spike is forgotten after a while.

A trip clears on its own after a recovery interval. It clears at once if the both-switch option is on and the load-present input goes low. If the overcurrent persists, the trip repeats and the counter keeps climbing. Once the counter reaches the programmed latch limit, the block holds the switches off in a latched state. The latch releases only after a separate, longer interval, and releasing it clears the counter. All intervals are counted on a single-cycle tick input, such as a millisecond strobe.

Top module: `ocp_guard`

## Requirements
- R1: A synchronous active-high reset clears the trip, latch and alert outputs and the fault counter, and drives both switch enables high.
- R2: The threshold is (cfg_i[3:0]+1)·2^STEP_SHIFT, doubled when cfg_i[8] is 1. The sample is signed, and only a value strictly greater than the threshold counts as over.
- R3: A trip needs (cfg_i[6:4]+1) ticks in a row with the sample over the threshold. Any cycle at or below the threshold restarts that count.
- R4: In the cycle after a trip qualifies, trip_o is 1, dsg_en_o is 0 and the fault counter has grown by one.
- R5: When cfg_i[7] is 1, chg_en_o is 0 whenever trip_o or latch_o is 1. Otherwise chg_en_o stays 1.
- R6: alert_o is 1 exactly when the fault counter is nonzero and latch_o is 0. The counter drops by one after each DEC_TICKS ticks, and every trip restarts that interval.
- R7: trip_o clears after RECOV_TICKS ticks. It also clears one cycle after cfg_i[7]=1 and load_present_i=0 are seen together. dsg_en_o returns to 1 only if latch_o is 0.
- R8: A trip that brings the counter to or above cfg_i[11:9] sets latch_o in the same cycle as trip_o, and alert_o goes to 0. A limit of 0 latches on the first trip. While latched, dsg_en_o is 0 and no new trip is counted.
- R9: latch_o clears after LRST_TICKS ticks. Clearing it sets the fault counter to zero, and the switches return only if trip_o is also 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_i | input | 1 | One-cycle timebase strobe |
| sample_i | input | SMP_W | Signed discharge-current sample |
| cfg_i | input | 12 | Limit [11:9], double [8], both-switch [7], delay [6:4], threshold [3:0] |
| load_present_i | input | 1 | Load still connected |
| trip_o | output | 1 | Trip status |
| latch_o | output | 1 | Latched fault status |
| alert_o | output | 1 | Fault counter nonzero and not latched |
| dsg_en_o | output | 1 | Discharge switch enable |
| chg_en_o | output | 1 | Charge switch enable |

## Verification
Samples held exactly at the threshold, negative samples and samples below a doubled threshold separate the strict comparison, the sign handling and the doubling bit. Over-threshold bursts one tick too short, each broken by a single low sample, separate a true qualification restart from a count that only pauses. A sustained overcurrent drives the full trip, recover and retrip cycle into the latch and then through latch release. A lone spike shows the counter draining without a latch. A load drop with the both-switch option on tells the early recovery path apart from the timed one. A latch limit of zero shows latching on the very first trip.

// File: rtl/ocp_pkg.sv
package ocp_pkg;

    localparam int CFG_W = 12;

    typedef struct packed {
        logic [2:0] latch_lim;
        logic       dbl;
        logic       both_off;
        logic [2:0] dly_code;
        logic [3:0] thr_code;
    } ocp_cfg_t;

    typedef struct packed {
        logic trip;
        logic latch;
    } ocp_state_t;

    function automatic int thr_level(ocp_cfg_t c, int step_shift);
        int base;
        base = (int'(c.thr_code) + 1) << step_shift;
        return c.dbl ? (base << 1) : base;
    endfunction

    function automatic int dly_ticks(ocp_cfg_t c);
        return int'(c.dly_code) + 1;
    endfunction

endpackage

// File: rtl/ocp_tick_timer.sv
module ocp_tick_timer #(
    parameter int LIMIT = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic run_i,
    input  logic tick_i,
    output logic expire_o
);
    localparam int W = $clog2(LIMIT + 1);

    logic [W-1:0] cnt;

    assign expire_o = run_i && tick_i && (cnt == W'(LIMIT - 1));

    always_ff @(posedge clk) begin
        if (rst || !run_i || expire_o) begin
            cnt <= '0;
        end else if (tick_i) begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/ocp_qualifier.sv
module ocp_qualifier
    import ocp_pkg::*;
#(
    parameter int SMP_W      = 16,
    parameter int STEP_SHIFT = 4
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    tick_i,
    input  logic                    armed_i,
    input  logic signed [SMP_W-1:0] sample_i,
    input  ocp_cfg_t                cfg_i,
    output logic                    above_o,
    output logic                    fire_o
);
    localparam int QW = 4;

    logic [QW-1:0] qcnt;
    logic signed [31:0] s_ext;
    int thr;
    logic last;

    always_comb begin
        s_ext   = 32'(sample_i);
        thr     = thr_level(cfg_i, STEP_SHIFT);
        above_o = s_ext > thr;
        last    = (int'(qcnt) + 1) >= dly_ticks(cfg_i);
        fire_o  = armed_i && above_o && tick_i && last;
    end

    always_ff @(posedge clk) begin
        if (rst || !armed_i || !above_o || fire_o) begin
            qcnt <= '0;
        end else if (tick_i) begin
            qcnt <= qcnt + 1'b1;
        end
    end
endmodule

// File: rtl/ocp_guard.sv
module ocp_guard
    import ocp_pkg::*;
#(
    parameter int SMP_W       = 16,
    parameter int STEP_SHIFT  = 4,
    parameter int CNT_W       = 3,
    parameter int RECOV_TICKS = 50,
    parameter int DEC_TICKS   = 200,
    parameter int LRST_TICKS  = 400
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    tick_i,
    input  logic signed [SMP_W-1:0] sample_i,
    input  logic [11:0]             cfg_i,
    input  logic                    load_present_i,
    output logic                    trip_o,
    output logic                    latch_o,
    output logic                    alert_o,
    output logic                    dsg_en_o,
    output logic                    chg_en_o
);
    ocp_cfg_t   cfg;
    ocp_state_t st;
    logic [CNT_W-1:0] fcnt;
    logic [CNT_W-1:0] fcnt_inc;
    logic above_thr, trip_evt, rec_exp, dec_exp, lrst_exp;
    logic early_rec, dec_run, off_any;

    assign cfg = ocp_cfg_t'(cfg_i);

    ocp_qualifier #(.SMP_W(SMP_W), .STEP_SHIFT(STEP_SHIFT)) u_qual (
        .clk(clk), .rst(rst), .tick_i(tick_i),
        .armed_i(!st.trip && !st.latch),
        .sample_i(sample_i), .cfg_i(cfg),
        .above_o(above_thr), .fire_o(trip_evt)
    );

    ocp_tick_timer #(.LIMIT(RECOV_TICKS)) u_rec (
        .clk(clk), .rst(rst), .run_i(st.trip), .tick_i(tick_i), .expire_o(rec_exp)
    );

    assign dec_run = (fcnt != '0) && !st.latch && !trip_evt;

    ocp_tick_timer #(.LIMIT(DEC_TICKS)) u_dec (
        .clk(clk), .rst(rst), .run_i(dec_run), .tick_i(tick_i), .expire_o(dec_exp)
    );

    ocp_tick_timer #(.LIMIT(LRST_TICKS)) u_lrst (
        .clk(clk), .rst(rst), .run_i(st.latch), .tick_i(tick_i), .expire_o(lrst_exp)
    );

    assign fcnt_inc  = (fcnt == '1) ? fcnt : fcnt + 1'b1;
    assign early_rec = cfg.both_off && !load_present_i;

    always_ff @(posedge clk) begin
        if (rst) begin
            st   <= '0;
            fcnt <= '0;
        end else begin
            if (trip_evt) begin
                st.trip <= 1'b1;
                fcnt    <= fcnt_inc;
                if (int'(fcnt_inc) >= int'(cfg.latch_lim)) begin
                    st.latch <= 1'b1;
                end
            end else begin
                if (st.trip && (rec_exp || early_rec)) begin
                    st.trip <= 1'b0;
                end
                if (lrst_exp) begin
                    st.latch <= 1'b0;
                    fcnt     <= '0;
                end else if (dec_exp) begin
                    fcnt <= fcnt - 1'b1;
                end
            end
        end
    end

    assign off_any  = st.trip || st.latch;
    assign trip_o   = st.trip;
    assign latch_o  = st.latch;
    assign alert_o  = (fcnt != '0) && !st.latch;
    assign dsg_en_o = !off_any;
    assign chg_en_o = !(off_any && cfg.both_off);
endmodule

// File: rtl/ocp_guard_chk.sv
module ocp_guard_chk (
    input logic clk,
    input logic rst,
    input logic above,
    input logic trip_o,
    input logic latch_o,
    input logic alert_o,
    input logic dsg_en_o,
    input logic chg_en_o
);
    a_r1_reset_clears: assert property (@(posedge clk)
        rst |=> (!trip_o && !latch_o && !alert_o && dsg_en_o && chg_en_o));

    a_r3_trip_needs_over: assert property (@(posedge clk) disable iff (rst)
        $rose(trip_o) |-> $past(above));

    a_r4_trip_opens_dsg: assert property (@(posedge clk) disable iff (rst)
        $rose(trip_o) |-> !dsg_en_o);

    a_r5_chg_not_alone: assert property (@(posedge clk) disable iff (rst)
        !chg_en_o |-> !dsg_en_o);

    a_r6_alert_from_trip: assert property (@(posedge clk) disable iff (rst)
        $rose(alert_o) |-> $rose(trip_o));

    a_r8_latch_with_trip: assert property (@(posedge clk) disable iff (rst)
        $rose(latch_o) |-> $rose(trip_o));

    a_r9_release_clears_alert: assert property (@(posedge clk) disable iff (rst)
        $fell(latch_o) |-> !alert_o);
endmodule

bind ocp_guard ocp_guard_chk u_chk (
    .clk(clk), .rst(rst), .above(above_thr),
    .trip_o(trip_o), .latch_o(latch_o), .alert_o(alert_o),
    .dsg_en_o(dsg_en_o), .chg_en_o(chg_en_o)
);

// File: tb/ocp_guard_test.sv
module ocp_guard_test;
    localparam int SMP_W = 16;
    localparam int SHIFT = 4;
    localparam int RECOV = 6;
    localparam int DEC   = 10;
    localparam int LRST  = 12;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic tick = 1'b0;
    logic signed [SMP_W-1:0] sample = '0;
    logic [11:0] cfg = '0;
    logic load = 1'b1;
    logic trip_o, latch_o, alert_o, dsg_en_o, chg_en_o;

    int n_tests = 0;
    int n_fail = 0;
    int cyc = 0;
    int tick_ph = 0;
    bit tick_every = 1'b1;
    string phase = "R1 reset";
    bit seen_trip, seen_latch, seen_alert;

    // reference state
    int m_trip, m_latch, m_fcnt, m_qual, m_rec, m_dec, m_lr;

    always #5 clk = ~clk;

    ocp_guard #(.SMP_W(SMP_W), .STEP_SHIFT(SHIFT), .CNT_W(3),
                .RECOV_TICKS(RECOV), .DEC_TICKS(DEC), .LRST_TICKS(LRST)) uut (
        .clk(clk), .rst(rst), .tick_i(tick), .sample_i(sample), .cfg_i(cfg),
        .load_present_i(load), .trip_o(trip_o), .latch_o(latch_o),
        .alert_o(alert_o), .dsg_en_o(dsg_en_o), .chg_en_o(chg_en_o)
    );

    function automatic logic [11:0] mk(int lim, int dbl, int both, int dly, int thr);
        return {3'(lim), 1'(dbl), 1'(both), 3'(dly), 4'(thr)};
    endfunction

    // tick generator, driven just after the edge
    always @(posedge clk) begin
        #1;
        tick_ph = (tick_ph + 1) % 3;
        tick = tick_every ? 1'b1 : (tick_ph == 0);
    end

    // behavioural reference model
    always @(posedge clk) begin
        int thr, dly, lim, fire, o_trip, o_latch, o_fcnt;
        if (rst) begin
            m_trip = 0; m_latch = 0; m_fcnt = 0;
            m_qual = 0; m_rec = 0; m_dec = 0; m_lr = 0;
        end else begin
            o_trip = m_trip; o_latch = m_latch; o_fcnt = m_fcnt;
            thr = (int'(cfg[3:0]) + 1) * (1 << SHIFT) * (cfg[8] ? 2 : 1);
            dly = int'(cfg[6:4]) + 1;
            lim = int'(cfg[11:9]);
            fire = 0;
            if (o_trip != 0 || o_latch != 0 || int'(sample) <= thr) m_qual = 0;
            else if (tick) begin
                if (m_qual + 1 >= dly) begin fire = 1; m_qual = 0; end
                else m_qual++;
            end
            if (fire != 0) begin
                m_trip = 1;
                if (o_fcnt < 7) m_fcnt = o_fcnt + 1;
                if (m_fcnt >= lim) m_latch = 1;
                m_dec = 0;
            end else begin
                if (o_trip != 0 && tick && m_rec + 1 == RECOV) m_trip = 0;
                if (o_trip != 0 && cfg[7] && !load) m_trip = 0;
                if (o_latch != 0 && tick && m_lr + 1 == LRST) begin
                    m_latch = 0; m_fcnt = 0;
                end else if (o_fcnt != 0 && o_latch == 0 && tick && m_dec + 1 == DEC) begin
                    m_fcnt = o_fcnt - 1;
                end
            end
            // interval counters follow the old state
            if (o_trip == 0) m_rec = 0;
            else if (tick) m_rec = (m_rec + 1 == RECOV) ? 0 : m_rec + 1;
            if (o_latch == 0) m_lr = 0;
            else if (tick) m_lr = (m_lr + 1 == LRST) ? 0 : m_lr + 1;
            if (fire != 0 || o_fcnt == 0 || o_latch != 0) m_dec = 0;
            else if (tick) m_dec = (m_dec + 1 == DEC) ? 0 : m_dec + 1;
        end
    end

    // compare every cycle, away from the active edge
    always @(negedge clk) begin
        logic e_alert, e_dsg, e_chg;
        e_alert = (m_fcnt != 0) && (m_latch == 0);
        e_dsg   = (m_trip == 0) && (m_latch == 0);
        e_chg   = !(!e_dsg && cfg[7]);
        n_tests++;
        if (trip_o !== 1'(m_trip) || latch_o !== 1'(m_latch) || alert_o !== e_alert ||
            dsg_en_o !== e_dsg || chg_en_o !== e_chg) begin
            n_fail++;
            $display("FAIL %s cyc %0d: trip/latch/alert/dsg/chg got %b%b%b%b%b exp %b%b%b%b%b",
                     phase, cyc, trip_o, latch_o, alert_o, dsg_en_o, chg_en_o,
                     1'(m_trip), 1'(m_latch), e_alert, e_dsg, e_chg);
        end
        if (trip_o === 1'b1) seen_trip = 1'b1;
        if (latch_o === 1'b1) seen_latch = 1'b1;
        if (alert_o === 1'b1) seen_alert = 1'b1;
    end

    task automatic check(string req, logic got, logic exp);
        n_tests++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %b exp %b", req, got, exp);
        end
    endtask

    task automatic go(int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic new_phase(string p);
        phase = p;
        seen_trip = 1'b0; seen_latch = 1'b0; seen_alert = 1'b0;
    endtask

    task automatic until_trip(int max);
        for (int i = 0; i < max && trip_o !== 1'b1; i++) @(negedge clk);
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000) begin
            n_fail++;
            $display("FAIL watchdog: got timeout exp completion");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        go(3);
        rst = 1'b0;
        @(negedge clk);
        check("R1 trip after reset", trip_o, 1'b0);
        check("R1 dsg after reset", dsg_en_o, 1'b1);
        check("R1 chg after reset", chg_en_o, 1'b1);
        go(1);

        // R2: strict comparison, sign, doubling
        new_phase("R2 threshold");
        cfg = mk(3, 0, 0, 1, 3);          // threshold 64, 2 ticks
        sample = 16'sd64;
        go(30);
        check("R2 at-threshold no trip", seen_trip, 1'b0);
        sample = -16'sd300;
        go(20);
        check("R2 negative no trip", seen_trip, 1'b0);
        cfg = mk(3, 1, 0, 1, 3);          // doubled to 128
        sample = 16'sd120;
        go(20);
        check("R2 below doubled no trip", seen_trip, 1'b0);
        sample = 16'sd129;
        go(6);
        check("R2 above doubled trips", seen_trip, 1'b1);
        sample = '0;
        go(80);                            // let trip recover and counter drain

        // R3: qualification restarts on any low sample
        new_phase("R3 qualify");
        cfg = mk(3, 0, 0, 3, 3);          // 4 ticks
        for (int k = 0; k < 10; k++) begin
            sample = 16'sd100; go(3);
            sample = 16'sd50;  go(1);
        end
        check("R3 broken bursts no trip", seen_trip, 1'b0);
        sample = 16'sd100;
        go(8);
        check("R3 sustained trips", seen_trip, 1'b1);

        // R4, R7, R8: persistent fault cycles into latch
        new_phase("R8 persistent");
        go(60);
        check("R8 latch reached", seen_latch, 1'b1);
        check("R4 dsg off while latched", dsg_en_o, latch_o ? 1'b0 : dsg_en_o);

        // R9: latch release
        new_phase("R9 release");
        sample = '0;
        go(60);
        @(negedge clk);
        check("R9 latch cleared", latch_o, 1'b0);
        check("R9 alert cleared", alert_o, 1'b0);
        check("R9 dsg back", dsg_en_o, 1'b1);
        go(1);

        // R6: lone spike then drain
        new_phase("R6 spike");
        tick_every = 1'b0;
        cfg = mk(5, 0, 0, 1, 3);
        sample = 16'sd100;
        until_trip(40);
        go(1);
        sample = '0;
        go(100);
        check("R6 alert seen", seen_alert, 1'b1);
        check("R6 alert drained", alert_o, 1'b0);

        // R5, R7: both switches off, early recovery on load removal
        new_phase("R5 both off");
        cfg = mk(5, 0, 1, 1, 3);
        load = 1'b1;
        sample = 16'sd100;
        until_trip(40);
        go(1);
        sample = '0;
        @(negedge clk);
        check("R5 chg off on trip", chg_en_o, 1'b0);
        check("R7 still tripped", trip_o, 1'b1);
        go(1);
        phase = "R7 load removed";
        load = 1'b0;
        go(1);
        @(negedge clk);
        check("R7 early recovery", trip_o, 1'b0);
        check("R7 chg back", chg_en_o, 1'b1);
        go(1);
        load = 1'b1;
        go(120);

        // R8: latch limit zero
        new_phase("R8 limit zero");
        cfg = mk(0, 0, 0, 1, 3);
        sample = 16'sd100;
        until_trip(40);
        check("R8 limit zero latches", latch_o, 1'b1);
        check("R8 no alert when latched", alert_o, 1'b0);
        go(1);
        sample = '0;
        go(80);

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule